// File: doc/BRIEF.md
# Configurable audio frame serializer

This block drives a three-wire serial audio output: a bit clock, a word-select line and a serial data line. Every frame is 64 bit slots long. Four fields share each frame: a 16-bit left sample, a 16-bit right sample and two 16-bit codec control words. Each field starts at its own programmable slot, and every field is sent MSB first. The bit clock runs at half the system clock, so one slot lasts two system cycles. A configuration bit chooses which bit-clock edge the data changes on.

The word-select line is either a level that stays active for half a frame or a pulse one slot wide. Its start slot and its polarity are programmable. Stereo sample pairs enter over a valid/ready port. The port is ready only in the last system cycle of each frame, and only while transmit is enabled. A pair accepted there is sent in the frame that follows. If `smp_valid_i` is low when the port is ready, nothing is lost upstream: the next frame carries zero samples and a sticky underrun flag is set. While transmit is disabled, frames keep running, the sample slots carry zero and the control words are still sent. An optional MSB inversion converts offset-binary samples to two's complement.

Top module: `afs_serializer`

## Requirements
- R1: After reset the block produces an endless run of 64-slot frames, each slot two system cycles long. `sck_o` equals the slot phase (0 in the first cycle of a slot, 1 in the second) XOR the frame's latched `clk_inv`.
- R2: During slot s, `sd_o` carries bit s of the frame image. The image is built from the left sample, the right sample, control word 1 (if enabled) and control word 2 (if enabled). A field starting at slot p places its bit 15 in slot p and its bit 0 in slot p+15, wrapping modulo 64. Slots outside every field are 0. Where fields overlap, control word 2 wins over control word 1, which wins over right, which wins over left.
- R3: In level mode (`ws_pulse`=0), word-select is active for the 32 slots starting at `ws_pos` (modulo 64). In pulse mode it is active only in slot `ws_pos`. `ws_o` is the active value XOR `ws_pol`.
- R4: `smp_ready_o` is 1 only in the last cycle of a frame (slot 63, second half) while `tx_en_i` is 1. A pair accepted in that cycle is sent in the next frame. The left sample is `smp_data_i[31:16]` and the right sample is `smp_data_i[15:0]`.
- R5: While `tx_en_i` is 0 at a frame boundary, the next frame is still produced. Its sample slots carry zero and the enabled control words carry their register values.
- R6: With `sign_cv_i`=1, bit 15 of both sample fields is inverted. This also applies to the zero values sent while transmit is off or after an underrun.
- R7: A control-word write (`cc1_we_i` / `cc2_we_i` with `cc_wdata_i`) made during a frame does not change the frame being sent. The new value appears from the next frame on.
- R8: If `smp_ready_o` is 1 and `smp_valid_i` is 0, the next frame carries zero samples and `underrun_o` rises one cycle later. The flag then holds until `underrun_clr_i` is pulsed outside a new underrun event.
- R9: All position, enable, polarity, clock-edge and word-select settings are sampled at the frame boundary (the last cycle of a frame). They govern only the following frame.
- R10: While reset is held: `sck_o`=0, `ws_o`=1, `sd_o`=0, `smp_ready_o`=0 and `underrun_o`=0. The first frame carries an all-zero image with default settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en_i | input | 1 | Transmit enable |
| sign_cv_i | input | 1 | Invert the sample MSB |
| ws_pol_i | input | 1 | Invert word-select |
| clk_inv_i | input | 1 | Select the bit-clock edge for data changes |
| ws_pulse_i | input | 1 | 1: one-slot pulse, 0: half-frame level |
| ws_pos_i | input | 6 | Word-select start slot |
| left_pos_i | input | 6 | Left sample start slot |
| right_pos_i | input | 6 | Right sample start slot |
| cc1_pos_i | input | 6 | Control word 1 start slot |
| cc2_pos_i | input | 6 | Control word 2 start slot |
| cc1_en_i | input | 1 | Insert control word 1 |
| cc2_en_i | input | 1 | Insert control word 2 |
| cc1_we_i | input | 1 | Write control word 1 register |
| cc2_we_i | input | 1 | Write control word 2 register |
| cc_wdata_i | input | 16 | Control word write data |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_data_i | input | 32 | Sample pair {left, right} |
| smp_ready_o | output | 1 | Sample pair accepted this cycle |
| underrun_clr_i | input | 1 | Clear the underrun flag |
| underrun_o | output | 1 | Sticky underrun flag |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word-select |
| sd_o | output | 1 | Serial data |

## Verification
The assertions assume that `underrun_clr_i` is a single-cycle pulse and that a producer keeps its pair stable while offering it. They also assume that control-word writes never fall on the boundary cycle. The stimulus enforces all of this. It changes configuration, sample data and valid only in the second cycle of a frame, and it writes control words only near mid-frame. Each configuration therefore crosses exactly one boundary, and the expected image for the next frame can be computed from the values held at that boundary.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int AFS_FRAME_BITS = 64;
  localparam int AFS_PW         = $clog2(AFS_FRAME_BITS);
  localparam int AFS_WORD       = 16;

  typedef struct packed {
    logic              ws_pol;
    logic              clk_inv;
    logic              ws_pulse;
    logic [AFS_PW-1:0] ws_pos;
  } afs_line_cfg_t;
endpackage

// File: rtl/afs_timer.sv
module afs_timer #(
  parameter int FRAME_BITS = afs_pkg::AFS_FRAME_BITS,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          ph_o,
  output logic [PW-1:0] slot_o,
  output logic          last_o
);
  logic          ph_q;
  logic [PW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      slot_q <= '0;
    end else begin
      ph_q <= ~ph_q;
      if (ph_q) slot_q <= slot_q + PW'(1);
    end
  end

  assign ph_o   = ph_q;
  assign slot_o = slot_q;
  assign last_o = ph_q && (slot_q == PW'(FRAME_BITS - 1));

  // R1
  ph_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ph_q != $past(ph_q));

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q |=> slot_q == $past(slot_q) + PW'(1));
endmodule

// File: rtl/afs_compose.sv
module afs_compose #(
  parameter int FRAME_BITS = afs_pkg::AFS_FRAME_BITS,
  parameter int WORD       = afs_pkg::AFS_WORD,
  localparam int PW = $clog2(FRAME_BITS),
  localparam int WB = $clog2(WORD)
) (
  input  logic [WORD-1:0]       left_i,
  input  logic [WORD-1:0]       right_i,
  input  logic [WORD-1:0]       cc1_i,
  input  logic [WORD-1:0]       cc2_i,
  input  logic [PW-1:0]         left_pos_i,
  input  logic [PW-1:0]         right_pos_i,
  input  logic [PW-1:0]         cc1_pos_i,
  input  logic [PW-1:0]         cc2_pos_i,
  input  logic                  cc1_en_i,
  input  logic                  cc2_en_i,
  output logic [FRAME_BITS-1:0] frame_o
);
  localparam logic [PW-1:0] WLEN = PW'(WORD);

  for (genvar s = 0; s < FRAME_BITS; s++) begin : g_slot
    logic [PW-1:0] d_l, d_r, d_1, d_2;
    logic          in_l, in_r, in_1, in_2;
    assign d_l  = PW'(s) - left_pos_i;
    assign d_r  = PW'(s) - right_pos_i;
    assign d_1  = PW'(s) - cc1_pos_i;
    assign d_2  = PW'(s) - cc2_pos_i;
    assign in_l = d_l < WLEN;
    assign in_r = d_r < WLEN;
    assign in_1 = cc1_en_i && (d_1 < WLEN);
    assign in_2 = cc2_en_i && (d_2 < WLEN);
    assign frame_o[s] = in_2 ? cc2_i[~d_2[WB-1:0]]
                      : in_1 ? cc1_i[~d_1[WB-1:0]]
                      : in_r ? right_i[~d_r[WB-1:0]]
                      : in_l ? left_i[~d_l[WB-1:0]]
                      : 1'b0;
  end
endmodule

// File: rtl/afs_serializer.sv
module afs_serializer #(
  parameter int FRAME_BITS = afs_pkg::AFS_FRAME_BITS,
  parameter int WORD       = afs_pkg::AFS_WORD,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_en_i,
  input  logic            sign_cv_i,
  input  logic            ws_pol_i,
  input  logic            clk_inv_i,
  input  logic            ws_pulse_i,
  input  logic [PW-1:0]   ws_pos_i,
  input  logic [PW-1:0]   left_pos_i,
  input  logic [PW-1:0]   right_pos_i,
  input  logic [PW-1:0]   cc1_pos_i,
  input  logic [PW-1:0]   cc2_pos_i,
  input  logic            cc1_en_i,
  input  logic            cc2_en_i,
  input  logic            cc1_we_i,
  input  logic            cc2_we_i,
  input  logic [WORD-1:0] cc_wdata_i,
  input  logic            smp_valid_i,
  input  logic [2*WORD-1:0] smp_data_i,
  output logic            smp_ready_o,
  input  logic            underrun_clr_i,
  output logic            underrun_o,
  output logic            sck_o,
  output logic            ws_o,
  output logic            sd_o
);
  import afs_pkg::*;

  localparam logic [PW-1:0] HALF = PW'(FRAME_BITS / 2);
  localparam logic [WORD-1:0] MSB_FLIP = {1'b1, {(WORD-1){1'b0}}};

  logic            ph, last;
  logic [PW-1:0]   slot;
  logic [WORD-1:0] cc1_q, cc2_q, left_v, right_v;
  logic [FRAME_BITS-1:0] next_img, img_q;
  afs_line_cfg_t   cfg_q;
  logic            underrun_q, take;
  logic [PW-1:0]   rel;

  afs_timer #(.FRAME_BITS(FRAME_BITS)) timer_i (
    .clk(clk), .rst_n(rst_n), .ph_o(ph), .slot_o(slot), .last_o(last)
  );

  assign smp_ready_o = last && tx_en_i;
  assign take        = smp_ready_o && smp_valid_i;
  assign left_v  = (take ? smp_data_i[2*WORD-1:WORD] : '0) ^ (sign_cv_i ? MSB_FLIP : '0);
  assign right_v = (take ? smp_data_i[WORD-1:0]      : '0) ^ (sign_cv_i ? MSB_FLIP : '0);

  afs_compose #(.FRAME_BITS(FRAME_BITS), .WORD(WORD)) compose_i (
    .left_i(left_v), .right_i(right_v), .cc1_i(cc1_q), .cc2_i(cc2_q),
    .left_pos_i(left_pos_i), .right_pos_i(right_pos_i),
    .cc1_pos_i(cc1_pos_i), .cc2_pos_i(cc2_pos_i),
    .cc1_en_i(cc1_en_i), .cc2_en_i(cc2_en_i), .frame_o(next_img)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc1_q      <= '0;
      cc2_q      <= '0;
      img_q      <= '0;
      cfg_q      <= '0;
      underrun_q <= 1'b0;
    end else begin
      if (cc1_we_i) cc1_q <= cc_wdata_i;
      if (cc2_we_i) cc2_q <= cc_wdata_i;
      if (last) begin
        img_q <= next_img;
        cfg_q <= '{ws_pol: ws_pol_i, clk_inv: clk_inv_i,
                   ws_pulse: ws_pulse_i, ws_pos: ws_pos_i};
      end
      if (smp_ready_o && !smp_valid_i) underrun_q <= 1'b1;
      else if (underrun_clr_i)         underrun_q <= 1'b0;
    end
  end

  assign rel        = slot - cfg_q.ws_pos;
  assign ws_o       = cfg_q.ws_pol ^ (cfg_q.ws_pulse ? (slot == cfg_q.ws_pos) : (rel < HALF));
  assign sck_o      = ph ^ cfg_q.clk_inv;
  assign sd_o       = img_q[slot];
  assign underrun_o = underrun_q;

  // R4
  ready_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready_o |=> (slot == '0) && !ph);

  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(img_q));

  // R8
  urun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready_o && !smp_valid_i) |=> underrun_o);

  // R8
  urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_o && !underrun_clr_i) |=> underrun_o);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(cfg_q));
endmodule

// File: tb/afs_serializer_tb_top.sv
`timescale 1ns/1ps
module afs_serializer_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tx_en, sign_cv, ws_pol, clk_inv, ws_pulse;
  logic [5:0] ws_pos, lpos, rpos, p1, p2;
  logic e1, e2, we1, we2, valid, ready, uclr, urun, sck, ws, sd;
  logic [15:0] wdata;
  logic [31:0] data;

  afs_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .sign_cv_i(sign_cv),
    .ws_pol_i(ws_pol), .clk_inv_i(clk_inv), .ws_pulse_i(ws_pulse),
    .ws_pos_i(ws_pos), .left_pos_i(lpos), .right_pos_i(rpos),
    .cc1_pos_i(p1), .cc2_pos_i(p2), .cc1_en_i(e1), .cc2_en_i(e2),
    .cc1_we_i(we1), .cc2_we_i(we2), .cc_wdata_i(wdata),
    .smp_valid_i(valid), .smp_data_i(data), .smp_ready_o(ready),
    .underrun_clr_i(uclr), .underrun_o(urun),
    .sck_o(sck), .ws_o(ws), .sd_o(sd)
  );

  int total = 0, bad = 0;
  bit done = 0;

  bit [63:0] m_vec;
  bit m_pol, m_inv, m_pulse, m_un;
  bit [5:0] m_wsp;
  bit [15:0] m_cc1, m_cc2;
  string cur_tag, pend_tag;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [63:0] put(bit [63:0] v, bit [15:0] w, bit [5:0] p);
    for (int i = 0; i < 64; i++) begin
      bit [5:0] d = 6'(i) - p;
      if (d < 16) v[i] = w[15 - d];
    end
    return v;
  endfunction

  function automatic bit [63:0] model_img(bit [15:0] l, bit [15:0] r);
    bit [63:0] v = '0;
    v = put(v, l, lpos);
    v = put(v, r, rpos);
    if (e1) v = put(v, m_cc1, p1);
    if (e2) v = put(v, m_cc2, p2);
    return v;
  endfunction

  function automatic bit exp_ws(int b);
    bit [5:0] rel = 6'(b) - m_wsp;
    bit act = m_pulse ? (6'(b) == m_wsp) : (rel < 32);
    return act ^ m_pol;
  endfunction

  task automatic set_cfg(int f);
    data  = $urandom;
    valid = 1'b1;
    case (f)
      1: begin  // reference layout
        lpos = 0; rpos = 32; p1 = 16; p2 = 48; e1 = 1; e2 = 1;
        ws_pulse = 1; clk_inv = 1; ws_pol = 1; ws_pos = 0;
        tx_en = 1; sign_cv = 0; pend_tag = "R2 R4";
      end
      2: begin
        tx_en = 0; sign_cv = 1; e1 = 1; e2 = 1; pend_tag = "R5 R6";
      end
      3: begin
        tx_en = 1; sign_cv = 1; valid = 0; pend_tag = "R8 R6";
      end
      4: begin
        lpos = 0; rpos = 8; p1 = 4; p2 = 60; e1 = 1; e2 = 1;
        tx_en = 1; sign_cv = 0; ws_pulse = 1; ws_pos = 63; pend_tag = "R2 R3";
      end
      5: begin
        tx_en = 1; sign_cv = 1; e1 = 0; e2 = 0; pend_tag = "R6";
      end
      default: begin
        lpos = 6'($urandom); rpos = 6'($urandom); p1 = 6'($urandom); p2 = 6'($urandom);
        e1 = 1'($urandom); e2 = 1'($urandom);
        ws_pol = 1'($urandom); clk_inv = 1'($urandom); ws_pulse = 1'($urandom);
        ws_pos = 6'($urandom); sign_cv = 1'($urandom);
        tx_en = ($urandom % 4) != 0; valid = ($urandom % 5) != 0;
        pend_tag = "R2 R3 R9";
      end
    endcase
  endtask

  initial begin
    int sd_err, ws_err, sck_err;
    void'($urandom(32'd20240607));
    rst_n = 0; tx_en = 0; sign_cv = 0; ws_pol = 0; clk_inv = 0; ws_pulse = 0;
    ws_pos = 0; lpos = 0; rpos = 32; p1 = 16; p2 = 48; e1 = 0; e2 = 0;
    we1 = 0; we2 = 0; wdata = 0; valid = 0; data = 0; uclr = 0;
    m_vec = '0; m_pol = 0; m_inv = 0; m_pulse = 0; m_wsp = 0; m_un = 0;
    m_cc1 = 0; m_cc2 = 0; cur_tag = "R10"; pend_tag = "R10";
    repeat (3) @(negedge clk);
    #1 chk("R10 reset outputs", {59'd0, sck, ws, sd, ready, urun}, {59'd0, 5'b01000});
    @(negedge clk);
    rst_n = 1;
    for (int f = 0; f < 40; f++) begin
      sd_err = 0; ws_err = 0; sck_err = 0;
      for (int c = 0; c < 128; c++) begin
        if (c == 1) set_cfg(f + 1);
        if (c == 60 && ($urandom % 2) == 1) begin
          wdata = $urandom;
          if ($urandom % 2) begin we1 = 1; m_cc1 = wdata; end
          else begin we2 = 1; m_cc2 = wdata; end
        end
        if (c == 61) begin we1 = 0; we2 = 0; end
        if (c == 70 && ($urandom % 3) == 0) begin uclr = 1; m_un = 0; end
        if (c == 71) uclr = 0;
        #1;
        if (sd  !== m_vec[c/2])          sd_err++;
        if (ws  !== exp_ws(c/2))         ws_err++;
        if (sck !== ((c % 2 == 1) ^ m_inv)) sck_err++;
        if (c == 0 && f > 0) chk("R8 underrun flag", 64'(urun), 64'(m_un));
        if (c == 72) chk("R8 underrun after clear window", 64'(urun), 64'(m_un));
        if (c == 50) chk("R4 ready idle mid-frame", 64'(ready), 64'd0);
        if (c == 127) begin
          bit [15:0] l, r;
          chk("R4 ready at boundary", 64'(ready), 64'(tx_en));
          chk({"R1 sck mismatches ", cur_tag}, 64'(sck_err), 64'd0);
          chk({"R3 ws mismatches ", cur_tag}, 64'(ws_err), 64'd0);
          chk({"R7 sd mismatches ", cur_tag}, 64'(sd_err), 64'd0);
          l = 0; r = 0;
          if (tx_en) begin
            if (valid) begin l = data[31:16]; r = data[15:0]; end
            else m_un = 1;
          end
          if (sign_cv) begin l[15] = ~l[15]; r[15] = ~r[15]; end
          m_vec = model_img(l, r);
          m_pol = ws_pol; m_inv = clk_inv; m_pulse = ws_pulse; m_wsp = ws_pos;
          cur_tag = pend_tag;
        end
        @(negedge clk);
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule